// File: doc/BRIEF.md
# Four-Bit Add/Subtract/Shift ALU

This block is a purely combinational arithmetic logic unit for 4-bit data. It takes two operands, `x_in` and `y_in`, and a 2-bit operation code. It returns a 4-bit result and a signed-overflow flag. The operations are two's-complement addition, two's-complement subtraction, a logical left shift and an arithmetic right shift. For the two shifts, the shift distance comes from the two low bits of `y_in`.

Inside, one adder/subtractor with carry-lookahead serves both arithmetic operations. For subtraction it inverts the second operand and forces the carry-in to 1. Two barrel shifters, each built from two multiplexer stages, produce the shifted values. A row of per-bit 4-to-1 multiplexers, steered by the operation code, picks each result bit and the overflow bit. The block has no clock and no state, so its outputs follow its inputs.

Top module: `alu4_core`

## Requirements
- R1: With `op_sel` = 2'b00, `f_out` equals (`x_in` + `y_in`) modulo 16.
- R2: With `op_sel` = 2'b01, `f_out` equals (`x_in` − `y_in`) modulo 16, formed as `x_in` + ~`y_in` + 1.
- R3: A subtraction whose signed result is −5 (for example 2 − 7) gives `f_out` = 4'hB.
- R4: With `op_sel` = 2'b10, `f_out` is `x_in` shifted left by n = `y_in[1:0]` places, and the vacated low bits are 0.
- R5: With `op_sel` = 2'b11, `f_out` is `x_in` shifted right by n = `y_in[1:0]` places, and every vacated high bit is a copy of `x_in[3]`.
- R6: In both shift operations, `y_in[3:2]` has no effect on `f_out` or `ovf_out`.
- R7: A shift distance of 0 passes `x_in` to `f_out` unchanged, for both shift directions.
- R8: With `op_sel` = 2'b00 or 2'b01, `ovf_out` is 1 exactly when the true signed result lies outside −8..7.
- R9: With `op_sel` = 2'b10 or 2'b11, `ovf_out` is 0.
- R10: The outputs depend only on the present inputs: a change of input is seen on the outputs with no clock edge, and the same inputs always give the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 4 | First operand; the value that is shifted |
| y_in | input | 4 | Second operand; bits [1:0] give the shift distance |
| op_sel | input | 2 | Operation: 00 add, 01 subtract, 10 shift left logical, 11 shift right arithmetic |
| f_out | output | 4 | Result |
| ovf_out | output | 1 | Signed overflow of add/subtract; 0 for shifts |

## Verification
Every operand pair is applied under every operation code and compared with an integer model. This covers all carry chains, all sign combinations for overflow, and every shift distance on both positive and negative operands. Directed cases then target specific distinctions:
- The −5 subtraction and the most-negative/most-positive overflow pairs separate a correct overflow rule from one that reads the wrong carry.
- Shifts repeated with only `y_in[3:2]` changed show that those bits are ignored.
- Negative operands under the right shift separate sign fill from zero fill.
- Back-to-back input changes with no clock between them show that the block holds no state.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_SHL = 2'b10,
        OP_SAR = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu4_addsub_cla.sv
module alu4_addsub_cla #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_opd,
    input  logic [W-1:0] b_opd,
    input  logic         do_sub,
    output logic [W-1:0] sum_o,
    output logic         ovf_o
);
    logic [W-1:0] b_eff;
    logic [W-1:0] gen_v;
    logic [W-1:0] prp_v;
    logic [W:0]   cry;

    assign b_eff = b_opd ^ {W{do_sub}};
    assign gen_v = a_opd & b_eff;
    assign prp_v = a_opd ^ b_eff;

    // flattened lookahead: each carry is a sum of products of g/p and carry-in
    always_comb begin
        cry[0] = do_sub;
        for (int i = 0; i < W; i++) begin
            logic term_acc;
            logic prp_run;
            term_acc = 1'b0;
            for (int j = 0; j <= i; j++) begin
                prp_run = gen_v[j];
                for (int k = j + 1; k <= i; k++) prp_run = prp_run & prp_v[k];
                term_acc = term_acc | prp_run;
            end
            prp_run = do_sub;
            for (int k = 0; k <= i; k++) prp_run = prp_run & prp_v[k];
            cry[i+1] = term_acc | prp_run;
        end
    end

    assign sum_o = prp_v ^ cry[W-1:0];
    assign ovf_o = cry[W] ^ cry[W-1];

    always_comb begin
        // R8
        ovf_sign_chk: assert (!ovf_o || ((a_opd[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_opd[W-1])));
        // R8
        no_ovf_sign_chk: assert (ovf_o || (a_opd[W-1] != b_eff[W-1]) || (sum_o[W-1] == a_opd[W-1]));
    end
endmodule

// File: rtl/alu4_barrel.sv
module alu4_barrel #(
    parameter int W         = 4,
    parameter bit SHIFT_RIGHT = 1'b0
) (
    input  logic [W-1:0]         d_in,
    input  logic [$clog2(W)-1:0] amt,
    output logic [W-1:0]         d_out
);
    localparam int SW = $clog2(W);

    logic [W-1:0] stg [0:SW];

    assign stg[0] = d_in;

    generate
        for (genvar k = 0; k < SW; k++) begin : g_stage
            localparam int SH = 1 << k;
            logic [W-1:0] moved;
            if (SHIFT_RIGHT) begin : g_sar
                assign moved = {{SH{stg[k][W-1]}}, stg[k][W-1:SH]};
            end else begin : g_shl
                assign moved = {stg[k][W-1-SH:0], {SH{1'b0}}};
            end
            assign stg[k+1] = amt[k] ? moved : stg[k];
        end
    endgenerate

    assign d_out = stg[SW];

    always_comb begin
        // R7
        zero_amt_pass_chk: assert (amt != '0 || d_out == d_in);
        if (SHIFT_RIGHT) begin
            // R5
            sign_keep_chk: assert (d_out[W-1] == d_in[W-1]);
        end else begin
            // R4
            low_fill_chk: assert (amt == '0 || d_out[0] == 1'b0);
        end
    end
endmodule

// File: rtl/alu4_outmux.sv
module alu4_outmux #(
    parameter int NB = 5
) (
    input  logic [1:0]    sel,
    input  logic [NB-1:0] src0,
    input  logic [NB-1:0] src1,
    input  logic [NB-1:0] src2,
    input  logic [NB-1:0] src3,
    output logic [NB-1:0] y_out
);
    generate
        for (genvar b = 0; b < NB; b++) begin : g_lane
            logic lo_pick;
            logic hi_pick;
            assign lo_pick  = sel[0] ? src1[b] : src0[b];
            assign hi_pick  = sel[0] ? src3[b] : src2[b];
            assign y_out[b] = sel[1] ? hi_pick : lo_pick;
        end
    endgenerate

    always_comb begin
        // R1
        lane_src0_chk: assert (sel != 2'b00 || y_out == src0);
        // R4
        lane_src2_chk: assert (sel != 2'b10 || y_out == src2);
    end
endmodule

// File: rtl/alu4_core.sv
module alu4_core #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic [1:0]   op_sel,
    output logic [W-1:0] f_out,
    output logic         ovf_out
);
    import alu4_pkg::*;

    localparam int SW = $clog2(W);
    localparam int NB = W + 1;

    alu_op_e      op_q;
    logic [W-1:0] arith_res;
    logic         arith_ovf;
    logic [W-1:0] shl_res;
    logic [W-1:0] sar_res;
    logic [NB-1:0] picked;

    assign op_q = alu_op_e'(op_sel);

    alu4_addsub_cla #(.W(W)) u_addsub (
        .a_opd (x_in),
        .b_opd (y_in),
        .do_sub(op_sel[0]),
        .sum_o (arith_res),
        .ovf_o (arith_ovf)
    );

    alu4_barrel #(.W(W), .SHIFT_RIGHT(1'b0)) u_shl (
        .d_in (x_in),
        .amt  (y_in[SW-1:0]),
        .d_out(shl_res)
    );

    alu4_barrel #(.W(W), .SHIFT_RIGHT(1'b1)) u_sar (
        .d_in (x_in),
        .amt  (y_in[SW-1:0]),
        .d_out(sar_res)
    );

    alu4_outmux #(.NB(NB)) u_mux (
        .sel  (op_sel),
        .src0 ({arith_ovf, arith_res}),
        .src1 ({arith_ovf, arith_res}),
        .src2 ({1'b0, shl_res}),
        .src3 ({1'b0, sar_res}),
        .y_out(picked)
    );

    assign f_out   = picked[W-1:0];
    assign ovf_out = picked[W];

    always_comb begin
        // R9
        no_overflow_chk: assert (!(op_q == OP_SHL || op_q == OP_SAR) || ovf_out == 1'b0);
        // R2
        sub_result_chk: assert (op_q != OP_SUB || f_out == arith_res);
    end
endmodule

// File: tb/sim_alu4_core.sv
module sim_alu4_core;
    logic       clk = 1'b0;
    logic [3:0] x_in;
    logic [3:0] y_in;
    logic [1:0] op_sel;
    logic [3:0] f_out;
    logic       ovf_out;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    alu4_core u0 (
        .x_in   (x_in),
        .y_in   (y_in),
        .op_sel (op_sel),
        .f_out  (f_out),
        .ovf_out(ovf_out)
    );

    function automatic logic [4:0] model(input int x, input int y, input int op);
        int sx, sy, r, n;
        logic [3:0] f;
        logic o;
        sx = (x > 7) ? x - 16 : x;
        sy = (y > 7) ? y - 16 : y;
        n = y % 4;
        o = 1'b0;
        case (op)
            0: begin r = sx + sy; o = (r > 7 || r < -8); f = 4'(r); end
            1: begin r = sx - sy; o = (r > 7 || r < -8); f = 4'(r); end
            2: f = 4'((x * (1 << n)) % 16);
            default: begin r = sx; for (int k = 0; k < n; k++) r = (r < 0) ? -((1 - r) / 2) : r / 2; f = 4'(r); end
        endcase
        return {o, f};
    endfunction

    task automatic apply(input int x, input int y, input int op);
        x_in = 4'(x); y_in = 4'(y); op_sel = 2'(op);
        #1;
    endtask

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s x=%h y=%h op=%0d act ovf/f=%b/%h exp ovf/f=%b/%h",
                     req, x_in, y_in, op_sel, act[4], act[3:0], exp[4], exp[3:0]);
        end
    endtask

    task automatic t_idle_state;
        apply(0, 0, 0);
        check("R1 zero inputs", {ovf_out, f_out}, 5'b0);
    endtask

    task automatic t_exhaustive;
        for (int op = 0; op < 4; op++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++) begin
                    apply(x, y, op);
                    case (op)
                        0: check("R1/R8 add", {ovf_out, f_out}, model(x, y, op));
                        1: check("R2/R8 sub", {ovf_out, f_out}, model(x, y, op));
                        2: check("R4/R9 shl", {ovf_out, f_out}, model(x, y, op));
                        default: check("R5/R9 sar", {ovf_out, f_out}, model(x, y, op));
                    endcase
                end
    endtask

    task automatic t_minus_five;
        apply(2, 7, 1);
        check("R3 2-7", {ovf_out, f_out}, 5'h0B);
        apply(4'hD, 2, 1);
        check("R3 -3-2", {ovf_out, f_out}, 5'h0B);
    endtask

    task automatic t_overflow_edges;
        apply(7, 1, 0);  check("R8 7+1", {ovf_out, f_out}, {1'b1, 4'h8});
        apply(8, 8, 0);  check("R8 -8+-8", {ovf_out, f_out}, {1'b1, 4'h0});
        apply(8, 1, 1);  check("R8 -8-1", {ovf_out, f_out}, {1'b1, 4'h7});
        apply(0, 8, 1);  check("R8 0-(-8)", {ovf_out, f_out}, {1'b1, 4'h8});
        apply(15, 1, 0); check("R8 -1+1", {ovf_out, f_out}, {1'b0, 4'h0});
    endtask

    task automatic t_upper_y_ignored;
        logic [4:0] ref_v;
        for (int op = 2; op < 4; op++)
            for (int n = 0; n < 4; n++) begin
                apply(4'hA, n, op);
                ref_v = {ovf_out, f_out};
                for (int hi = 1; hi < 4; hi++) begin
                    apply(4'hA, hi * 4 + n, op);
                    check("R6 y[3:2] ignored", {ovf_out, f_out}, ref_v);
                end
            end
    endtask

    task automatic t_pass_through;
        apply(4'h9, 4'hC, 2); check("R7 shl by 0", {ovf_out, f_out}, 5'h09);
        apply(4'h9, 4'h4, 3); check("R7 sar by 0", {ovf_out, f_out}, 5'h09);
        apply(4'h8, 3, 3);    check("R5 sign fill", {ovf_out, f_out}, 5'h0F);
        apply(4'h6, 3, 2);    check("R9 shl ovf low", {ovf_out, f_out}, 5'h00);
    endtask

    task automatic t_no_state;
        apply(3, 4, 0); check("R10 first", {ovf_out, f_out}, 5'h07);
        apply(3, 4, 1); check("R10 change no clock", {ovf_out, f_out}, 5'h0F);
        apply(3, 4, 0); check("R10 repeat", {ovf_out, f_out}, 5'h07);
    endtask

    initial begin
        t_idle_state();
        t_exhaustive();
        t_minus_five();
        t_overflow_edges();
        t_upper_y_ignored();
        t_pass_through();
        t_no_state();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R10 act=hung exp=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule